// File: doc/BRIEF.md
# Tape Record Transfer Sequencer

This block moves a record between a byte-wide host data channel and a byte-addressed tape image. It is one stage of a tape controller. Command decode sits upstream and hands it one of four operations: read a record, write a record, write a file mark, or write a gap. On a record read, the sequencer fetches the leading length word and qualifies it. A good record is copied into an internal buffer, and its bytes are then offered to the host one per byte interval, each with a data flag. On a record write, the sequencer gathers host bytes into the buffer while the transfer flop stays set. When the host drops that flop, the sequencer lays the record onto the medium.

A record on the medium is a 32-bit length word, stored least significant byte first. The data bytes follow, plus one zero pad byte when the length is odd, and then a copy of the length word. A length of zero is a file mark. The block keeps the current medium position and a small set of status bits. At the end of every operation it raises a completion (control) flag. Two inputs set the timing: a start delay before the first service of a command, and a byte interval between later services. The values 1000 and 10 clocks are the usual settings.

Top module: `tape_xfer_seq`

## Requirements
- R1: After reset, `busy`, `cflag`, `dflag`, `st_eof`, `st_eot`, `st_par`, `st_tim` are 0 and `pos` is 0.
- R2: A read whose length word is zero advances `pos` by 4, sets `st_eof`, ends the command and raises `cflag`.
- R3: A read for which `pos`+4 exceeds `med_end` sets `st_eot`, leaves `pos` unchanged, ends the command and raises `cflag`, and delivers no byte.
- R4: A read whose length is below 12 or above `BUF_BYTES` (default 256) sets `st_par` and delivers no byte. It still advances `pos` by the length rounded up to even plus 8.
- R5: A good read advances `pos` by the padded length plus 8. It delivers the record bytes in order on `out_byte`, one per service, each with `dflag` set. A byte whose address is at or beyond `med_end` is delivered as zero.
- R6: When a read service finds `dflag` still set and not being cleared that cycle, `st_tim` is set.
- R7: After the last byte of a read has been delivered, the next service raises `cflag` and drops `busy`.
- R8: On a write, the first service stores nothing. Each later service that finds the transfer flop set stores `host_byte` into the buffer and sets `dflag`. A byte beyond `BUF_BYTES` sets `st_par` and is discarded.
- R9: When a write service finds the transfer flop cleared with N>0 bytes held, the medium receives the following at `pos`: the length word, the data, a zero pad byte if N is odd, and the length word again. `pos` then advances by the padded N plus 8. With N=0 nothing is written. Either way `cflag` rises.
- R10: A file mark writes four zero bytes, advances `pos` by 4 and sets `st_eof`. A gap writes nothing and leaves `pos` unchanged. Both raise `cflag`.
- R11: `cmd_op` encodes 0 read, 1 write, 2 gap, 3 file mark. `cmd_go` is accepted only when `busy` is 0. A pulse during a command has no effect on it.
- R12: While idle, `pos` holds and `med_we` stays 0.
- R13: The first service of a command comes no earlier than `start_dly` cycles after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Start pulse for the operation in `cmd_op` |
| cmd_op | input | 2 | 0 read, 1 write, 2 gap, 3 file mark |
| start_dly | input | 24 | Cycles from accept to first service |
| byte_dly | input | 24 | Cycles between byte services |
| xfer_clr | input | 1 | Host clears the transfer flop (ends a write) |
| dflag_clr | input | 1 | Host acknowledges the data flag |
| host_byte | input | 8 | Byte offered by the host on writes |
| out_byte | output | 8 | Byte delivered to the host on reads |
| dflag | output | 1 | Data flag |
| cflag | output | 1 | Completion flag |
| busy | output | 1 | A command is in progress |
| st_eof | output | 1 | File mark read or written |
| st_eot | output | 1 | End of medium reached |
| st_par | output | 1 | Bad record length or buffer overflow |
| st_tim | output | 1 | Host too slow on a read |
| pos | output | 32 | Current medium byte position |
| med_end | input | 32 | Number of valid bytes on the medium |
| med_addr | output | 32 | Medium byte address |
| med_rd | input | 8 | Medium read data (same cycle as address) |
| med_wr | output | 8 | Medium write data |
| med_we | output | 1 | Medium write strobe |

## Verification
A wrong record length or buffer index shows up at once as a bad byte on `out_byte` at the next data flag. When the command ends, it also leaves a `pos` that misses its expected record boundary, so a fault in the state moves the position of every later command. A fault in the commit path leaves wrong bytes at fixed medium addresses, and the bench's medium model holds them there to be compared. Status faults appear on the status pins in the same cycle that `cflag` rises.

// File: rtl/tape_xfer_seq.sv
module tape_xfer_seq #(
  parameter int BUF_BYTES = 256,
  parameter int MIN_LEN   = 12,
  parameter int TW        = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic [1:0]    cmd_op,
  input  logic [TW-1:0] start_dly,
  input  logic [TW-1:0] byte_dly,
  input  logic          xfer_clr,
  input  logic          dflag_clr,
  input  logic [7:0]    host_byte,
  output logic [7:0]    out_byte,
  output logic          dflag,
  output logic          cflag,
  output logic          busy,
  output logic          st_eof,
  output logic          st_eot,
  output logic          st_par,
  output logic          st_tim,
  output logic [31:0]   pos,
  input  logic [31:0]   med_end,
  output logic [31:0]   med_addr,
  input  logic [7:0]    med_rd,
  output logic [7:0]    med_wr,
  output logic          med_we
);
  localparam int IW = $clog2(BUF_BYTES);
  localparam int AW = $clog2(BUF_BYTES + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_GAP = 2'd2, OP_FM = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_DLY, S_HDR, S_LOAD, S_RWAIT, S_WWAIT, S_COMMIT} st_t;

  st_t           st;
  logic [1:0]    op;
  logic [TW-1:0] tmr;
  logic [31:0]   idx, len, base, cm_end;
  logic [AW-1:0] ptr;
  logic          xfer, first;
  logic [7:0]    mem [BUF_BYTES];

  wire        tick    = (tmr <= TW'(1));
  wire [31:0] hdr_w   = {med_rd, len[31:8]};
  wire [31:0] hdr_pad = (hdr_w + 32'd1) & ~32'd1;
  wire [31:0] plen    = (len + 32'd1) & ~32'd1;
  wire [31:0] tix     = idx - 32'd4 - plen;
  wire [IW-1:0] bix   = IW'(idx - 32'd4);
  wire        in_med  = (med_addr < med_end);
  wire        xf_on   = xfer && !xfer_clr;
  wire        wr_svc  = (st == S_WWAIT) && tick && xf_on && !first;
  wire        room    = (32'(ptr) < 32'(BUF_BYTES));

  assign busy     = (st != S_IDLE);
  assign med_addr = base + idx;
  assign med_we   = (st == S_COMMIT);

  always_comb begin
    if (idx < 32'd4)             med_wr = 8'(len >> (8 * idx));
    else if (idx < 32'd4 + len)  med_wr = mem[bix];
    else if (idx < 32'd4 + plen) med_wr = 8'h00;
    else                         med_wr = 8'(len >> (8 * tix));
  end

  always_ff @(posedge clk) begin
    if (st == S_LOAD)       mem[bix] <= in_med ? med_rd : 8'h00;
    else if (wr_svc && room) mem[ptr[IW-1:0]] <= host_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_RD; tmr <= '0; idx <= '0; len <= '0; base <= '0;
      cm_end <= '0; ptr <= '0; xfer <= 1'b0; first <= 1'b0; out_byte <= '0;
      dflag <= 1'b0; cflag <= 1'b0; pos <= '0;
      st_eof <= 1'b0; st_eot <= 1'b0; st_par <= 1'b0; st_tim <= 1'b0;
    end else begin
      if (xfer_clr)  xfer  <= 1'b0;
      if (dflag_clr) dflag <= 1'b0;
      case (st)
        S_IDLE: if (cmd_go) begin
          op <= cmd_op; base <= pos; tmr <= start_dly; st <= S_DLY;
          cflag <= 1'b0; dflag <= 1'b0; xfer <= 1'b1; first <= 1'b1;
          ptr <= '0; idx <= '0; len <= '0;
          st_eof <= 1'b0; st_eot <= 1'b0; st_par <= 1'b0; st_tim <= 1'b0;
        end
        S_DLY: if (!tick) tmr <= tmr - TW'(1);
        else case (op)
          OP_RD: if (({1'b0, pos} + 33'd4) > {1'b0, med_end}) begin
                   st_eot <= 1'b1; st <= S_IDLE; cflag <= 1'b1;
                 end else st <= S_HDR;
          OP_WR: begin st <= S_WWAIT; tmr <= TW'(1); end
          OP_GAP: begin st <= S_IDLE; cflag <= 1'b1; end
          default: begin cm_end <= 32'd4; st <= S_COMMIT; end
        endcase
        S_HDR: begin
          len <= hdr_w;
          idx <= idx + 32'd1;
          if (idx == 32'd3) begin
            if (hdr_w == 32'd0) begin
              pos <= base + 32'd4; st_eof <= 1'b1; st <= S_IDLE; cflag <= 1'b1;
            end else begin
              pos <= base + hdr_pad + 32'd8;
              if (hdr_w > 32'(BUF_BYTES) || hdr_w < 32'(MIN_LEN)) begin
                st_par <= 1'b1; st <= S_IDLE; cflag <= 1'b1;
              end else st <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          idx <= idx + 32'd1;
          if (idx == len + 32'd3) begin st <= S_RWAIT; tmr <= byte_dly; ptr <= '0; end
        end
        S_RWAIT: if (!tick) tmr <= tmr - TW'(1);
        else if (32'(ptr) < len) begin
          if (dflag && !dflag_clr) st_tim <= 1'b1;
          out_byte <= mem[ptr[IW-1:0]];
          dflag <= 1'b1;
          ptr <= ptr + AW'(1);
          tmr <= byte_dly;
        end else begin
          st <= S_IDLE; cflag <= 1'b1;
        end
        S_WWAIT: if (!tick) tmr <= tmr - TW'(1);
        else if (xf_on) begin
          if (!first) begin
            if (room) ptr <= ptr + AW'(1);
            else      st_par <= 1'b1;
          end
          first <= 1'b0; dflag <= 1'b1; tmr <= byte_dly;
        end else if (ptr != '0) begin
          len <= 32'(ptr); idx <= '0;
          cm_end <= ((32'(ptr) + 32'd1) & ~32'd1) + 32'd8;
          st <= S_COMMIT;
        end else begin
          st <= S_IDLE; cflag <= 1'b1;
        end
        S_COMMIT: begin
          idx <= idx + 32'd1;
          if (idx == cm_end - 32'd1) begin
            pos <= base + cm_end;
            if (op == OP_FM) st_eof <= 1'b1;
            st <= S_IDLE; cflag <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tape_xfer_seq_chk.sv
module tape_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_go,
  input logic        busy,
  input logic        cflag,
  input logic        dflag,
  input logic        st_tim,
  input logic        med_we,
  input logic [31:0] pos,
  input logic [1:0]  op
);
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    med_we |-> busy);                                                   // R9
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cflag) |-> !busy);                                            // R7
  AST_POS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(pos));                          // R12
  AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_go) |=> $stable(op));                                  // R11
  AST_DFLAG_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dflag) |-> busy);                                             // R5
  AST_TIM_AFTER_DFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tim) |-> $past(dflag));                                    // R6
endmodule

bind tape_xfer_seq tape_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .busy(busy), .cflag(cflag),
  .dflag(dflag), .st_tim(st_tim), .med_we(med_we), .pos(pos), .op(op)
);

// File: tb/test_tape_xfer_seq.sv
module test_tape_xfer_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cmd_go, xfer_clr, dflag_clr;
  logic [1:0]  cmd_op;
  logic [23:0] start_dly, byte_dly;
  logic [7:0]  host_byte, out_byte, med_rd, med_wr;
  logic        dflag, cflag, busy, st_eof, st_eot, st_par, st_tim, med_we;
  logic [31:0] pos, med_end, med_addr;

  tape_xfer_seq i_tape_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op),
    .start_dly(start_dly), .byte_dly(byte_dly), .xfer_clr(xfer_clr),
    .dflag_clr(dflag_clr), .host_byte(host_byte), .out_byte(out_byte),
    .dflag(dflag), .cflag(cflag), .busy(busy), .st_eof(st_eof), .st_eot(st_eot),
    .st_par(st_par), .st_tim(st_tim), .pos(pos), .med_end(med_end),
    .med_addr(med_addr), .med_rd(med_rd), .med_wr(med_wr), .med_we(med_we)
  );

  // Layout: 13-byte record @0, mark @22, 5-byte @26, 12-byte @40, 300-byte @60, 16-byte @368 cut at 382
  function automatic logic [7:0] init_byte(input int a);
    case (a)
      0: return 8'd13;
      26: return 8'd5;
      40: return 8'd12;
      60: return 8'h2C;
      61: return 8'h01;
      368: return 8'd16;
      1, 2, 3, 22, 23, 24, 25, 27, 28, 29, 41, 42, 43, 62, 63, 369, 370, 371: return 8'h00;
      default: return 8'(a * 37 + 5);
    endcase
  endfunction

  logic [7:0] tape [0:1023];
  int we_cnt = 0;
  assign med_rd = tape[med_addr[9:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) tape[i] <= init_byte(i);
    end else if (med_we) begin
      tape[med_addr[9:0]] <= med_wr;
      we_cnt <= we_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R13 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o);
    cmd_op = o; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] wbyte(input int v0, input int i);
    return 8'(v0 + i * 17);
  endfunction

  task automatic wr_rec(input int n, input int v0);
    issue(2'd1);
    for (int i = 0; i <= n; i++) begin
      while (!dflag) @(negedge clk);
      if (i < n) host_byte = wbyte(v0, i);
      else       xfer_clr = 1'b1;
      dflag_clr = 1'b1;
      @(negedge clk);
      dflag_clr = 1'b0; xfer_clr = 1'b0;
    end
    wait_idle();
  endtask

  // Read table: bytes delivered, end position, flags {eof,eot,par,tim}, slow host
  localparam int RN = 7;
  localparam int RD_NB  [RN] = '{13, 0, 0, 12, 0, 16, 0};
  localparam int RD_POS [RN] = '{22, 26, 40, 60, 368, 392, 392};
  localparam int RD_FLG [RN] = '{0, 8, 2, 1, 2, 0, 4};
  localparam int RD_SLOW[RN] = '{0, 0, 0, 1, 0, 0, 0};

  initial begin
    rst_n = 1'b0; cmd_go = 1'b0; cmd_op = 2'd0; xfer_clr = 1'b0; dflag_clr = 1'b0;
    host_byte = 8'h00; start_dly = 24'd1000; byte_dly = 24'd10; med_end = 32'd382;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1", "busy", busy, 0);
    chk("R1", "cflag", cflag, 0);
    chk("R1", "dflag", dflag, 0);
    chk("R1", "pos", pos, 0);
    chk("R1", "status", {st_eof, st_eot, st_par, st_tim}, 0);

    for (int e = 0; e < RN; e++) begin
      int got, base, t0;
      got = 0;
      base = (e == 0) ? 0 : RD_POS[e-1];
      issue(2'd0);
      t0 = cyc;
      while (busy) begin
        if (dflag && RD_SLOW[e] == 0) begin
          int a;
          a = base + 4 + got;
          if (e == 0 && got == 0) chk("R13", "start delay respected", (cyc - t0) >= 1000, 1);
          chk("R5", "read byte", out_byte, (a < int'(med_end)) ? tape[a] : 8'h00);
          got++;
          dflag_clr = 1'b1;
          if (e == 0 && got == 1) begin cmd_op = 2'd3; cmd_go = 1'b1; end
          @(negedge clk);
          dflag_clr = 1'b0; cmd_go = 1'b0;
        end else if (dflag) begin
          repeat (15) @(negedge clk);
          dflag_clr = 1'b1;
          @(negedge clk);
          dflag_clr = 1'b0;
        end else @(negedge clk);
      end
      if (RD_SLOW[e] == 0) chk("R5", "bytes delivered", got, RD_NB[e]);
      chk("R5", "end position", pos, RD_POS[e]);
      chk("R2", "eof", st_eof, (RD_FLG[e] >> 3) & 1);
      chk("R3", "eot", st_eot, (RD_FLG[e] >> 2) & 1);
      chk("R4", "par", st_par, (RD_FLG[e] >> 1) & 1);
      chk("R6", "tim", st_tim, RD_FLG[e] & 1);
      chk("R7", "cflag at end", cflag, 1);
      if (e == 0) chk("R11", "go during read ignored, no eof", st_eof, 0);
    end

    med_end = 32'd1024;

    wr_rec(3, 8'hAA);
    chk("R8", "first stored byte", tape[396], 8'hAA);
    chk("R9", "head lo", tape[392], 3);
    chk("R9", "head hi", {tape[393], tape[394], tape[395]}, 0);
    chk("R9", "data 1", tape[397], 8'hBB);
    chk("R9", "data 2", tape[398], 8'hCC);
    chk("R9", "pad zero", tape[399], 0);
    chk("R9", "trail", {tape[403], tape[402], tape[401], tape[400]}, 3);
    chk("R9", "pos", pos, 404);
    chk("R9", "cflag", cflag, 1);
    chk("R8", "no overflow", st_par, 0);

    begin
      int w0;
      w0 = we_cnt;
      wr_rec(0, 0);
      chk("R9", "zero write no medium writes", we_cnt - w0, 0);
      chk("R9", "zero write pos", pos, 404);
      chk("R9", "zero write cflag", cflag, 1);
    end

    issue(2'd3);
    wait_idle();
    chk("R10", "mark bytes", {tape[404], tape[405], tape[406], tape[407]}, 0);
    chk("R10", "mark pos", pos, 408);
    chk("R10", "mark eof", st_eof, 1);
    chk("R10", "mark cflag", cflag, 1);

    begin
      int w0;
      w0 = we_cnt;
      issue(2'd2);
      wait_idle();
      chk("R10", "gap no writes", we_cnt - w0, 0);
      chk("R10", "gap pos", pos, 408);
      chk("R10", "gap cflag", cflag, 1);
      chk("R10", "gap eof clear", st_eof, 0);
      repeat (5) @(negedge clk);
      chk("R12", "idle pos hold", pos, 408);
      chk("R12", "idle no writes", we_cnt - w0, 0);
    end

    wr_rec(257, 0);
    chk("R8", "overflow par", st_par, 1);
    chk("R9", "full head", {tape[411], tape[410], tape[409], tape[408]}, 256);
    chk("R8", "full first byte", tape[412], wbyte(0, 0));
    chk("R8", "full last byte", tape[667], wbyte(0, 255));
    chk("R9", "full trail", {tape[671], tape[670], tape[669], tape[668]}, 256);
    chk("R9", "full pos", pos, 672);

    summary();
  end
endmodule